// File: doc/BRIEF.md
# Speculative Two-Class Crossbar Switch Allocator

This block decides, every cycle, which input virtual channels of a router may move a flit across the crossbar. Each of the P inputs has V virtual channels. Each VC can request one output port, and each request is marked as either committed (non-speculative) or speculative. Body and tail flits, and head flits that already own an output VC, always arrive as committed requests. A head flit that is still competing for an output VC in the same cycle arrives as a speculative request. Alongside it comes a flag that says whether its VC allocation succeeded.

Two separable input-first allocators work side by side, one per request class. In each one, a V:1 round-robin arbiter at every input picks a single VC. A P:1 round-robin arbiter at every output then picks a single input among the winners that target it. Committed winners always stand. A speculative winner is dropped if its output is already taken by a committed winner, if its input already holds a committed grant, or if its head flit failed VC allocation that cycle. Grants and crossbar selects are combinational. Arbiter priorities are registered and move only for grants that reach the output.

Top module: `xbar_spec_alloc`

## Requirements
- R1: VC k of input i has flat index n = i*V + k. Its requested output is `req_port[n*IW +: IW]`, which must be below P, and it is speculative when `req_spec[n]` is 1. A VC with `req_vld[n]` low is never granted.
- R2: In every cycle each input receives at most one grant across its VCs, and each output is granted to at most one VC.
- R3: Each input keeps one VC priority pointer per class. After a surviving grant to VC v in that class, the search at that input starts from VC (v+1) mod V. The other class's pointer is left unchanged.
- R4: Each output keeps one input priority pointer per class. After a surviving grant from input i in that class, the search at that output starts from input (i+1) mod P.
- R5: A speculative winner is suppressed when a committed grant uses the same output or the same input in that cycle.
- R6: A speculative winner whose `req_va_ok` bit is 0 is not granted.
- R7: Suppressed speculative winners do not move any pointer, so with unchanged inputs the same choice is made again in the next cycle.
- R8: `out_vld[o]` is 1 exactly when output o carries a grant. `out_sel[o*IW +: IW]` then holds the index of the granted input, and it is 0 when the output is idle.
- R9: Reset sets every pointer to 0, so the lowest-numbered VC and input win first after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the priority pointers |
| req_vld | input | P*V | Request present, one bit per input VC |
| req_spec | input | P*V | Request is speculative, one bit per input VC |
| req_va_ok | input | P*V | VC allocation succeeded this cycle, one bit per input VC |
| req_port | input | P*V*IW | Requested output port, IW bits per input VC |
| gnt | output | P*V | Final grant, one bit per input VC |
| out_vld | output | P | Output port carries a grant |
| out_sel | output | P*IW | Crossbar select per output: granted input index |

## Verification
The first directed patterns come right after reset: a set of committed requests that all contend for one output, repeated over several cycles. These show the reset winner and the rotation of both pointer levels, and they tell the input stage apart from the output stage. Next, speculative requests with failed VC allocation are held for two cycles and then allowed to succeed. This separates a dropped grant that leaves the pointers alone from one that advances them. Mixed committed and speculative requests that collide on an output, and then on an input, expose the masking rules. Finally, a long pseudo-random sweep over a 3-port, 2-VC configuration compares every grant and crossbar select against a cycle-accurate arithmetic model.

// File: rtl/xbar_spec_alloc.sv
module xbar_spec_alloc #(
  parameter int P = 5,
  parameter int V = 4,
  localparam int N  = P * V,
  localparam int IW = (P > 1) ? $clog2(P) : 1,
  localparam int VW = (V > 1) ? $clog2(V) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    req_vld,
  input  logic [N-1:0]    req_spec,
  input  logic [N-1:0]    req_va_ok,
  input  logic [N*IW-1:0] req_port,
  output logic [N-1:0]    gnt,
  output logic [P-1:0]    out_vld,
  output logic [P*IW-1:0] out_sel
);

  // class 0: committed requests, class 1: speculative requests
  logic [VW-1:0] in_ptr     [2][P];
  logic [VW-1:0] in_ptr_nx  [2][P];
  logic [IW-1:0] out_ptr    [2][P];
  logic [IW-1:0] out_ptr_nx [2][P];

  logic          s1_v  [2][P];
  logic [VW-1:0] s1_vc [2][P];
  logic [IW-1:0] s1_pt [2][P];
  logic          s2_v  [2][P];
  logic [IW-1:0] s2_in [2][P];
  logic [P-1:0]  in_busy;

  always_comb begin
    for (int c = 0; c < 2; c++) begin
      for (int i = 0; i < P; i++) begin
        s1_v[c][i]  = 1'b0;
        s1_vc[c][i] = '0;
        s1_pt[c][i] = '0;
        for (int k = 0; k < V; k++) begin
          automatic int v = (int'(in_ptr[c][i]) + k) % V;
          automatic int n = i * V + v;
          if (!s1_v[c][i] && req_vld[n] && (req_spec[n] == (c == 1))) begin
            s1_v[c][i]  = 1'b1;
            s1_vc[c][i] = VW'(v);
            s1_pt[c][i] = req_port[n*IW +: IW];
          end
        end
      end
    end
  end

  always_comb begin
    for (int c = 0; c < 2; c++) begin
      for (int o = 0; o < P; o++) begin
        s2_v[c][o]  = 1'b0;
        s2_in[c][o] = '0;
        for (int k = 0; k < P; k++) begin
          automatic int i = (int'(out_ptr[c][o]) + k) % P;
          if (!s2_v[c][o] && s1_v[c][i] && (int'(s1_pt[c][i]) == o)) begin
            s2_v[c][o]  = 1'b1;
            s2_in[c][o] = IW'(i);
          end
        end
      end
    end
  end

  always_comb begin
    gnt        = '0;
    out_vld    = '0;
    out_sel    = '0;
    in_busy    = '0;
    in_ptr_nx  = in_ptr;
    out_ptr_nx = out_ptr;
    for (int o = 0; o < P; o++) begin
      if (s2_v[0][o]) begin
        automatic int i = int'(s2_in[0][o]);
        automatic int v = int'(s1_vc[0][i]);
        gnt[i*V + v]           = 1'b1;
        out_vld[o]             = 1'b1;
        out_sel[o*IW +: IW]    = IW'(i);
        in_busy[i]             = 1'b1;
        out_ptr_nx[0][o]       = IW'((i + 1) % P);
        in_ptr_nx[0][i]        = VW'((v + 1) % V);
      end
    end
    for (int o = 0; o < P; o++) begin
      if (s2_v[1][o] && !out_vld[o]) begin
        automatic int i = int'(s2_in[1][o]);
        automatic int v = int'(s1_vc[1][i]);
        if (!in_busy[i] && req_va_ok[i*V + v]) begin
          gnt[i*V + v]         = 1'b1;
          out_vld[o]           = 1'b1;
          out_sel[o*IW +: IW]  = IW'(i);
          in_busy[i]           = 1'b1;
          out_ptr_nx[1][o]     = IW'((i + 1) % P);
          in_ptr_nx[1][i]      = VW'((v + 1) % V);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < 2; c++) begin
        for (int i = 0; i < P; i++) begin
          in_ptr[c][i]  <= '0;
          out_ptr[c][i] <= '0;
        end
      end
    end else begin
      in_ptr  <= in_ptr_nx;
      out_ptr <= out_ptr_nx;
    end
  end

endmodule

// File: rtl/xbar_spec_alloc_chk.sv
module xbar_spec_alloc_chk #(
  parameter int P = 5,
  parameter int V = 4,
  localparam int N  = P * V,
  localparam int IW = (P > 1) ? $clog2(P) : 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic [N-1:0]    req_vld,
  input logic [N-1:0]    req_spec,
  input logic [N-1:0]    req_va_ok,
  input logic [N*IW-1:0] req_port,
  input logic [N-1:0]    gnt,
  input logic [P-1:0]    out_vld,
  input logic [P*IW-1:0] out_sel
);

  int           cnt [P];
  logic [P-1:0] hit_sel;

  always_comb begin
    for (int o = 0; o < P; o++) begin
      cnt[o]     = 0;
      hit_sel[o] = 1'b0;
      for (int n = 0; n < N; n++) begin
        if (gnt[n] && int'(req_port[n*IW +: IW]) == o) begin
          cnt[o] = cnt[o] + 1;
          if (n / V == int'(out_sel[o*IW +: IW])) hit_sel[o] = 1'b1;
        end
      end
    end
  end

  AST_GNT_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt & ~req_vld) == '0); // R1

  AST_VA_FAIL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt & req_spec & ~req_va_ok) == '0); // R6

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt == '0) |=> (!$stable(req_vld) || !$stable(req_spec) ||
                     !$stable(req_va_ok) || !$stable(req_port) || gnt == '0)); // R7

  for (genvar i = 0; i < P; i++) begin : g_in
    AST_IN_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt[i*V +: V])); // R2
  end

  for (genvar o = 0; o < P; o++) begin : g_out
    AST_OUT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      cnt[o] <= 1); // R2
    AST_VLD_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld[o] == (cnt[o] != 0)); // R8
    AST_SEL_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld[o] |-> hit_sel[o]); // R8
  end

endmodule

bind xbar_spec_alloc xbar_spec_alloc_chk #(.P(P), .V(V)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_spec(req_spec),
  .req_va_ok(req_va_ok), .req_port(req_port), .gnt(gnt),
  .out_vld(out_vld), .out_sel(out_sel)
);

// File: tb/tb_xbar_spec_alloc.sv
module tb_xbar_spec_alloc;
  localparam int P = 3, V = 2, N = P * V, IW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0]    req_vld = '0, req_spec = '0, req_va_ok = '0;
  logic [N*IW-1:0] req_port = '0;
  logic [N-1:0]    gnt;
  logic [P-1:0]    out_vld;
  logic [P*IW-1:0] out_sel;

  int nchk = 0, nfail = 0;
  bit done = 0;
  int mi[2][P], mo[2][P];
  int w1[2][P];
  logic [N-1:0] e_gnt;
  logic [P-1:0] e_vld;
  int e_sel[P], e_cls[P];
  logic [31:0] rng = 32'h1234_5679;

  xbar_spec_alloc #(.P(P), .V(V)) dut (.*);

  always #2 clk = ~clk;

  task automatic chk(bit ok, string tag, int act, int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic set_vc(int i, int k, bit v, bit s, bit ok, int port);
    req_vld[i*V+k] = v; req_spec[i*V+k] = s; req_va_ok[i*V+k] = ok;
    req_port[(i*V+k)*IW +: IW] = IW'(port);
  endtask

  task automatic model();
    bit busy[P];
    for (int c = 0; c < 2; c++)
      for (int i = 0; i < P; i++) begin
        w1[c][i] = -1;
        for (int k = 0; k < V; k++) begin
          int v, n;
          v = (mi[c][i] + k) % V; n = i*V + v;
          if (w1[c][i] < 0 && req_vld[n] && int'(req_spec[n]) == c) w1[c][i] = v;
        end
      end
    e_gnt = '0; e_vld = '0;
    for (int i = 0; i < P; i++) busy[i] = 0;
    for (int c = 0; c < 2; c++)
      for (int o = 0; o < P; o++) begin
        int win; win = -1;
        for (int k = 0; k < P; k++) begin
          int i; i = (mo[c][o] + k) % P;
          if (win < 0 && w1[c][i] >= 0 && int'(req_port[(i*V+w1[c][i])*IW +: IW]) == o) win = i;
        end
        if (win >= 0 && !e_vld[o] && !busy[win] &&
            (c == 0 || req_va_ok[win*V+w1[c][win]])) begin
          e_gnt[win*V+w1[c][win]] = 1'b1; e_vld[o] = 1'b1;
          e_sel[o] = win; e_cls[o] = c; busy[win] = 1;
        end
      end
  endtask

  task automatic advance();
    for (int o = 0; o < P; o++)
      if (e_vld[o]) begin
        mo[e_cls[o]][o] = (e_sel[o] + 1) % P;
        mi[e_cls[o]][e_sel[o]] = (w1[e_cls[o]][e_sel[o]] + 1) % V;
      end
  endtask

  task automatic step(string tag, bit use_x, logic [N-1:0] xg);
    #1;
    model();
    chk(gnt == e_gnt, {tag, " R1 R2 gnt vs model"}, int'(gnt), int'(e_gnt));
    chk(out_vld == e_vld, {tag, " R8 out_vld"}, int'(out_vld), int'(e_vld));
    for (int o = 0; o < P; o++)
      chk(int'(out_sel[o*IW +: IW]) == (e_vld[o] ? e_sel[o] : 0),
          {tag, " R8 out_sel"}, int'(out_sel[o*IW +: IW]), e_vld[o] ? e_sel[o] : 0);
    if (use_x) chk(gnt == xg, {tag, " explicit gnt"}, int'(gnt), int'(xg));
    @(posedge clk);
    advance();
    @(negedge clk);
  endtask

  initial begin
    for (int c = 0; c < 2; c++) for (int i = 0; i < P; i++) begin mi[c][i] = 0; mo[c][i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step("R9 reset idle", 1, '0);

    // R9, R3, R4: committed contention for output 0
    set_vc(0, 0, 1, 0, 1, 0); set_vc(0, 1, 1, 0, 1, 0); set_vc(1, 0, 1, 0, 1, 0);
    step("R9 first winner", 1, 6'b000001);
    step("R3 R4 rotate", 1, 6'b000100);
    step("R3 R4 rotate again", 1, 6'b000010);

    // R6, R7: speculative with failed VC allocation
    req_vld = '0;
    set_vc(0, 0, 1, 1, 0, 0); set_vc(0, 1, 1, 1, 1, 0);
    step("R6 va fail", 1, '0);
    step("R7 pointer held", 1, '0);
    set_vc(0, 0, 1, 1, 1, 0);
    step("R7 retry wins", 1, 6'b000001);
    step("R3 spec rotate", 1, 6'b000010);

    // R5: output conflict
    req_vld = '0;
    set_vc(0, 0, 1, 0, 1, 1); set_vc(1, 0, 1, 1, 1, 1); set_vc(2, 0, 1, 1, 1, 2);
    step("R5 output mask", 1, 6'b010001);
    // R5: input conflict
    req_vld = '0;
    set_vc(2, 0, 1, 1, 1, 2); set_vc(2, 1, 1, 0, 1, 0);
    step("R5 input mask", 1, 6'b100000);

    // sweep against the model
    for (int t = 0; t < 4000; t++) begin
      for (int n = 0; n < N; n++) begin
        rng = rng ^ (rng << 13); rng = rng ^ (rng >> 17); rng = rng ^ (rng << 5);
        set_vc(n / V, n % V, rng[0] | rng[1], rng[2], rng[3] | rng[4], int'(rng[15:8]) % P);
      end
      step("R3 R4 R5 R6 R7 sweep", 0, '0);
    end

    done = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end
endmodule